// File: doc/BRIEF.md
# Serial Peripheral Error Flag Unit

This block keeps the four error status flags of a serial (SPI/I2S) peripheral and turns them into one error interrupt. The data path reports each error as a single-cycle pulse on `evt_pulse`. The block latches that pulse into a sticky flag and holds it until software performs the clear action that belongs to that flag. The event detectors, the shift register and the CRC engine are outside this block.

Software reaches the block over a small register bus. That bus has separate read and write strobes, an address, and write data. Three addresses matter: status, data and control. Two flags clear through plain writes to the status address. The other two clear only after an ordered pair of accesses. A small state machine per flag tracks that pair. Each machine has two states:

- `SEQ_IDLE`: nothing is armed.
- `SEQ_ARMED`: the first step was seen while the flag was set.

The transitions are:

- **arm**: `SEQ_IDLE` to `SEQ_ARMED`, on the first step while the flag is set.
- **fire**: `SEQ_ARMED` to `SEQ_IDLE`, on the second step. This clears the flag.
- **rearm**: `SEQ_ARMED` to `SEQ_ARMED`, on a repeated first step.
- **abandon**: `SEQ_ARMED` to `SEQ_IDLE`, on any other bus access.
- **hold**: stay in the current state on cycles with no bus access.

Flag order on `err_flags` is:

| Bit | Flag |
|---|---|
| 0 | Configuration fault |
| 1 | Receive overrun |
| 2 | CRC mismatch |
| 3 | Frame format error |

The default address map is:

| Address | Register |
|---|---|
| 0 | Status |
| 1 | Data |
| 2 | Control |
| 3 | Unused |

Top module: `errflag_unit`

## Requirements
- R1: After reset, `err_flags` is 0 and `err_irq` is 0. Neither sequence machine is armed, so a second step issued right after reset clears nothing.
- R2: A pulse on `evt_pulse[i]` sets `err_flags[i]` at the next clock edge. The bit mapping is 0 configuration fault, 1 receive overrun, 2 CRC mismatch, 3 frame format error. Several pulses in one cycle set several flags.
- R3: The configuration fault flag (bit 0) clears only when a status access (read or write, address 0) is followed, as the next bus access, by a control write (address 2).
- R4: The receive overrun flag (bit 1) clears only when a data read (address 1) is followed, as the next bus access, by a status read (address 0).
- R5: A status write with `bus_wdata[4]` = 0 clears the CRC flag (bit 2). A status write with `bus_wdata[4]` = 1 leaves that flag unchanged.
- R6: A status write with `bus_wdata[8]` = 0 clears the frame format flag (bit 3). A status write with `bus_wdata[8]` = 1 leaves that flag unchanged.
- R7: A first step arms a two-step clear only if its flag is already set in that cycle. A flag that sets after the first step is not cleared by the second step.
- R8: When a set pulse and a clear action hit the same flag in the same cycle, the flag ends up set.
- R9: An armed sequence is abandoned by any intervening bus access that is neither its first nor its second step. Idle cycles between the two steps do not abandon it. A repeated first step keeps it armed.
- R10: `err_irq` is 1 exactly when `err_ie` is 1 and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 4 | Error event pulses from the data path, one bit per flag |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| err_ie | input | 1 | Shared error interrupt enable |
| err_flags | output | 4 | Sticky error flags |
| err_irq | output | 1 | Error interrupt request |

## Verification
A sequence machine stuck in the wrong state shows up at the ports on the very next bus access:

- If it is left armed, a lone second step clears a flag that should have stayed set.
- If it is dropped wrongly, a correct two-step pair leaves the flag set.

Because of this, the bench reads `err_flags` one edge after every step, including steps separated by idle cycles or by foreign accesses. A wrong set/clear priority or bit position changes `err_flags` one edge after the offending cycle. The bench sweeps every event pattern and every value of the two clear bits.

// File: rtl/errflag_pkg.sv
package errflag_pkg;
    localparam int N_FLAG = 4;
    localparam int F_CFG  = 0;
    localparam int F_OVR  = 1;
    localparam int F_CRC  = 2;
    localparam int F_FRM  = 3;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;
endpackage

// File: rtl/errflag_seq.sv
module errflag_seq
    import errflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step1,
    input  logic step2,
    input  logic any_acc,
    input  logic flag_q,
    output logic clr_o
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        clr_o   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (step1 && flag_q) state_d = SEQ_ARMED;          // arm
            end
            SEQ_ARMED: begin
                if (step2) begin
                    clr_o   = 1'b1;                                // fire
                    state_d = SEQ_IDLE;
                end else if (step1) begin
                    state_d = SEQ_ARMED;                           // rearm
                end else if (any_acc) begin
                    state_d = SEQ_IDLE;                            // abandon
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end
endmodule

// File: rtl/errflag_bit.sv
module errflag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/errflag_unit.sv
module errflag_unit
    import errflag_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 16,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1,
    parameter int CTL_ADDR  = 2,
    parameter int CRC_BIT   = 4,
    parameter int FRM_BIT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] evt_pulse,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              err_ie,
    output logic [N_FLAG-1:0] err_flags,
    output logic              err_irq
);
    localparam logic [DATA_W-1:0] CRC_MASK = DATA_W'(1) << CRC_BIT;
    localparam logic [DATA_W-1:0] FRM_MASK = DATA_W'(1) << FRM_BIT;

    logic              hit_stat, hit_data, hit_ctl, any_acc;
    logic              crc_keep, frm_keep;
    logic [N_FLAG-1:0] clr_vec;
    logic [1:0]        s1_vec, s2_vec, seq_clr;

    assign hit_stat = (bus_addr == ADDR_W'(STAT_ADDR));
    assign hit_data = (bus_addr == ADDR_W'(DATA_ADDR));
    assign hit_ctl  = (bus_addr == ADDR_W'(CTL_ADDR));
    assign any_acc  = bus_rd | bus_wr;
    assign crc_keep = |(bus_wdata & CRC_MASK);
    assign frm_keep = |(bus_wdata & FRM_MASK);

    // sequence 0 serves the configuration fault, sequence 1 the overrun
    assign s1_vec[0] = any_acc && hit_stat;
    assign s2_vec[0] = bus_wr  && hit_ctl;
    assign s1_vec[1] = bus_rd  && hit_data;
    assign s2_vec[1] = bus_rd  && hit_stat;

    for (genvar s = 0; s < 2; s++) begin : g_seq
        errflag_seq u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .step1   (s1_vec[s]),
            .step2   (s2_vec[s]),
            .any_acc (any_acc),
            .flag_q  (err_flags[s]),
            .clr_o   (seq_clr[s])
        );
    end

    always_comb begin
        clr_vec        = '0;
        clr_vec[F_CFG] = seq_clr[0];
        clr_vec[F_OVR] = seq_clr[1];
        clr_vec[F_CRC] = bus_wr && hit_stat && !crc_keep;
        clr_vec[F_FRM] = bus_wr && hit_stat && !frm_keep;
    end

    for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
        errflag_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_pulse[f]),
            .clr_i (clr_vec[f]),
            .q_o   (err_flags[f])
        );
    end

    assign err_irq = err_ie && (err_flags != '0);
endmodule

// File: rtl/errflag_chk.sv
module errflag_chk #(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 16,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1,
    parameter int CTL_ADDR  = 2,
    parameter int CRC_BIT   = 4,
    parameter int FRM_BIT   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        evt_pulse,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              err_ie,
    input logic [3:0]        err_flags,
    input logic              err_irq
);
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != 4'd0) |=> ((err_flags & $past(evt_pulse)) == $past(evt_pulse)));

    assert_cfg_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flags[0]) |-> $past(bus_wr && bus_addr == ADDR_W'(CTL_ADDR)));

    assert_ovr_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flags[1]) |-> $past(bus_rd && bus_addr == ADDR_W'(STAT_ADDR)));

    assert_crc_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(STAT_ADDR) && bus_wdata[CRC_BIT] && err_flags[2])
        |=> err_flags[2]);

    assert_frm_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(STAT_ADDR) && bus_wdata[FRM_BIT] && err_flags[3])
        |=> err_flags[3]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_ie |-> !err_irq);

    assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ie && evt_pulse != 4'd0) |=> (err_irq || !err_ie));
endmodule

bind errflag_unit errflag_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR),
    .CTL_ADDR(CTL_ADDR), .CRC_BIT(CRC_BIT), .FRM_BIT(FRM_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .err_ie(err_ie),
    .err_flags(err_flags), .err_irq(err_irq)
);

// File: tb/errflag_unit_tb.sv
module errflag_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_STAT = 2'd0, A_DATA = 2'd1, A_CTL = 2'd2, A_NONE = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt_pulse = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        err_ie = 1'b0;
    logic [3:0]  err_flags;
    logic        err_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errflag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .err_ie(err_ie),
        .err_flags(err_flags), .err_irq(err_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, called and returning at a falling edge
    task automatic cyc(input logic rd, input logic wr, input logic [1:0] a,
                       input logic [15:0] d, input logic [3:0] ev);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; evt_pulse = ev;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; evt_pulse = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, A_NONE, 16'h0, 4'h0);
    endtask

    task automatic rd(input logic [1:0] a);                   cyc(1'b1, 1'b0, a, 16'h0, 4'h0); endtask
    task automatic wr(input logic [1:0] a, input logic [15:0] d); cyc(1'b0, 1'b1, a, d, 4'h0); endtask
    task automatic ev(input logic [3:0] p);                   cyc(1'b0, 1'b0, A_NONE, 16'h0, p); endtask

    task automatic clear_all;
        wr(A_STAT, 16'h0000);
        wr(A_CTL, 16'h0000);
        rd(A_DATA);
        rd(A_STAT);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after reset", 32'(err_flags), 32'h0);
        chk("R1 irq after reset", 32'(err_irq), 32'h0);

        // R1: no leftover arming; a lone second step clears nothing
        ev(4'h3);
        wr(A_CTL, 16'h0);
        rd(A_STAT);
        // the status read armed the cfg sequence; the overrun one was never armed
        chk("R1 no armed seq", 32'(err_flags), 32'h3);
        clear_all;
        chk("R1 clear_all", 32'(err_flags), 32'h0);

        // R2 / R10 sweep over all event patterns and enable
        for (int p = 0; p < 16; p++) begin
            for (int ie = 0; ie < 2; ie++) begin
                clear_all;
                err_ie = ie[0];
                ev(p[3:0]);
                chk("R2 event sets flags", 32'(err_flags), 32'(p));
                chk("R10 irq gating", 32'(err_irq), 32'((ie == 1) && (p != 0)));
            end
        end
        err_ie = 1'b1;

        // R5 / R6 sweep over both keep bits
        for (int w = 0; w < 4; w++) begin
            logic [15:0] d;
            clear_all;
            ev(4'hF);
            d = 16'h0003 | (16'(w & 1) << 4) | (16'((w >> 1) & 1) << 8);
            wr(A_STAT, d);
            chk("R5 R6 status write clears", 32'(err_flags),
                32'h3 | (32'(w & 1) << 2) | (32'((w >> 1) & 1) << 3));
        end
        clear_all;

        // R3 configuration fault sequences
        ev(4'h1); rd(A_STAT); wr(A_CTL, 16'h0);
        chk("R3 stat read then ctl write", 32'(err_flags), 32'h0);
        ev(4'h1); wr(A_STAT, 16'hFFFF); wr(A_CTL, 16'h0);
        chk("R3 stat write then ctl write", 32'(err_flags), 32'h0);
        ev(4'h1); rd(A_CTL); wr(A_CTL, 16'h0);
        chk("R3 wrong first step", 32'(err_flags), 32'h1);
        clear_all;

        // R4 receive overrun sequences
        ev(4'h2); rd(A_DATA); rd(A_STAT);
        chk("R4 data read then stat read", 32'(err_flags), 32'h0);
        ev(4'h2); rd(A_STAT); rd(A_DATA);
        chk("R4 reversed order keeps", 32'(err_flags), 32'h2);
        rd(A_STAT);
        chk("R4 completes after data read", 32'(err_flags), 32'h0);

        // R7 arming needs flag set at first step
        rd(A_STAT); ev(4'h1); wr(A_CTL, 16'h0);
        chk("R7 cfg late set not cleared", 32'(err_flags), 32'h1);
        rd(A_STAT); wr(A_CTL, 16'h0);
        chk("R7 cfg later pair clears", 32'(err_flags), 32'h0);
        rd(A_DATA); ev(4'h2); rd(A_STAT);
        chk("R7 ovr late set not cleared", 32'(err_flags), 32'h2);
        rd(A_DATA); rd(A_STAT);
        chk("R7 ovr later pair clears", 32'(err_flags), 32'h0);

        // R8 set wins over clear
        ev(4'h2); rd(A_DATA); cyc(1'b1, 1'b0, A_STAT, 16'h0, 4'h2);
        chk("R8 ovr set beats clear", 32'(err_flags), 32'h2);
        ev(4'h1); rd(A_STAT); cyc(1'b0, 1'b1, A_CTL, 16'h0, 4'h1);
        chk("R8 cfg set beats clear", 32'(err_flags), 32'h3);
        clear_all;
        ev(4'h4); cyc(1'b0, 1'b1, A_STAT, 16'h0, 4'h4);
        chk("R8 crc set beats clear", 32'(err_flags), 32'h4);
        clear_all;

        // R9 abandoning and holding
        ev(4'h2); rd(A_DATA); wr(A_CTL, 16'h0); rd(A_STAT);
        chk("R9 ovr abandoned by ctl write", 32'(err_flags), 32'h2);
        clear_all;
        ev(4'h2); rd(A_DATA); wr(A_NONE, 16'h0); rd(A_STAT);
        chk("R9 ovr abandoned by unused addr", 32'(err_flags), 32'h2);
        clear_all;
        ev(4'h1); rd(A_STAT); rd(A_DATA); wr(A_CTL, 16'h0);
        chk("R9 cfg abandoned by data read", 32'(err_flags), 32'h1);
        clear_all;
        ev(4'h1); rd(A_STAT); idle(3); wr(A_CTL, 16'h0);
        chk("R9 cfg idle keeps armed", 32'(err_flags), 32'h0);
        ev(4'h2); rd(A_DATA); rd(A_DATA); idle(2); rd(A_STAT);
        chk("R9 ovr rearm keeps armed", 32'(err_flags), 32'h0);
        chk("R10 irq low when clear", 32'(err_irq), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule